// File: doc/BRIEF.md
# Omega Multistage Packet Router

This block steers up to N single-word packets from N input ports to N output ports through a log2(N)-stage Omega network. Each stage holds N/2 two-by-two switching elements behind a perfect-shuffle link pattern. Every input port offers a valid flag, a destination index, a payload word and a broadcast flag. In one combinational pass the router sets every switch from the packet headers that reach it. The result is captured in a single output register.

A unicast packet follows one path, picking an output link at each stage from one bit of its destination. A broadcast packet puts every switch on its path into a broadcast setting, so its payload reaches all N outputs. Two packets that need the same switch output are not queued or retried. One of them is dropped, and the input that lost raises its blocked flag together with the delivered outputs. A surrounding system uses the blocked flags to decide what to offer again on a later cycle.

Top module: `omega_router`

## Requirements
- R1: While reset is low, and after reset until the first valid input, `outValid`, `outBlocked` and `outData` are all zero. Results for inputs present at a rising clock edge appear on the outputs right after that same edge, and they hold until the next edge.
- R2: A lone valid unicast packet on input i with destination d (`inDest[i*AW +: AW]`) shows up only at output d with its payload (`outData[d*W +: W]`), and `outBlocked` stays zero.
- R3: Links between stages use perfect-shuffle wiring: the link index is rotated left by one bit. The switch at stage k routes on destination bit AW-1-k. A value of 0 picks the switch's upper output (the even link) and 1 picks the lower output (the odd link).
- R4: Any set of unicast packets that meets no switch-output conflict under R3 is delivered in full, each packet at its own destination output.
- R5: When two unicast packets reach one switch and need the same output link, the packet on the upper input (even link after the shuffle) goes on. The packet on the lower input is dropped.
- R6: A lone valid broadcast packet sets `outValid` to all ones, and every output carries its payload.
- R7: A broadcast packet that meets any other packet at a switch goes on, and the other packet is dropped. When two broadcasts meet, the one on the upper input goes on.
- R8: `outBlocked[i]` is 1 exactly when some copy of input i's packet was dropped at any switch. It is never 1 for an input whose valid flag was low.
- R9: An output with `outValid` low shows an all-zero payload field.
- R10: When `inValid[i]` is low, the values on that port's broadcast flag, destination and payload have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | N | Packet present on each input port |
| inBcast | input | N | Broadcast request per input port |
| inDest | input | N*AW | Destination index per input, port i at bits i*AW +: AW |
| inData | input | N*W | Payload per input, port i at bits i*W +: W |
| outValid | output | N | Registered packet-present flag per output port |
| outData | output | N*W | Registered payload per output, port j at bits j*W +: W |
| outBlocked | output | N | Registered per-input flag: that input's packet was dropped |

## Verification
All three outputs are due exactly one rising edge after the inputs that produced them. The bench drives a new input vector on a falling edge and computes the expected delivery and blocking pattern at once with its own shuffle-and-switch model. It then compares the outputs on the next falling edge, after one rising edge has registered the result. Each vector therefore sees only its own result, and any extra or missing register stage shows up as a mismatch against a neighbouring vector. The sweep covers every permutation of an eight-port network, every lone unicast and broadcast, and random mixes with conflicts and broadcasts.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic [1:0] {
    SW_STRAIGHT = 2'd0,
    SW_CROSS    = 2'd1,
    SW_UP_BCAST = 2'd2,
    SW_LO_BCAST = 2'd3
  } swSetting_e;

  typedef struct packed {
    swSetting_e setting;
    logic       dropUpper;
    logic       dropLower;
  } swStrobe_t;

endpackage

// File: rtl/omega_sw_ctrl.sv
module omega_sw_ctrl
  import omega_pkg::*;
(
  input  logic      uValid,
  input  logic      uBcast,
  input  logic      uBit,
  input  logic      lValid,
  input  logic      lBcast,
  input  logic      lBit,
  output swStrobe_t strobe
);

  always_comb begin
    strobe = '{setting: SW_STRAIGHT, dropUpper: 1'b0, dropLower: 1'b0};
    if (uValid && lValid) begin
      if (uBcast) begin
        strobe.setting   = SW_UP_BCAST;
        strobe.dropLower = 1'b1;
      end else if (lBcast) begin
        strobe.setting   = SW_LO_BCAST;
        strobe.dropUpper = 1'b1;
      end else begin
        // upper packet decides the setting; lower loses on a clash
        strobe.setting   = uBit ? SW_CROSS : SW_STRAIGHT;
        strobe.dropLower = (uBit == lBit);
      end
    end else if (uValid) begin
      strobe.setting = uBcast ? SW_UP_BCAST : (uBit ? SW_CROSS : SW_STRAIGHT);
    end else if (lValid) begin
      strobe.setting = lBcast ? SW_LO_BCAST : (lBit ? SW_STRAIGHT : SW_CROSS);
    end
  end

endmodule

// File: rtl/omega_sw_dp.sv
module omega_sw_dp
  import omega_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          uValid,
  input  logic [LW-1:0] uLink,
  input  logic          lValid,
  input  logic [LW-1:0] lLink,
  input  swStrobe_t     strobe,
  output logic          oUValid,
  output logic [LW-1:0] oULink,
  output logic          oLValid,
  output logic [LW-1:0] oLLink
);

  logic uLive, lLive;

  assign uLive = uValid & ~strobe.dropUpper;
  assign lLive = lValid & ~strobe.dropLower;

  always_comb begin
    case (strobe.setting)
      SW_CROSS: begin
        oUValid = lLive; oULink = lLink;
        oLValid = uLive; oLLink = uLink;
      end
      SW_UP_BCAST: begin
        oUValid = uLive; oULink = uLink;
        oLValid = uLive; oLLink = uLink;
      end
      SW_LO_BCAST: begin
        oUValid = lLive; oULink = lLink;
        oLValid = lLive; oLLink = lLink;
      end
      default: begin
        oUValid = uLive; oULink = uLink;
        oLValid = lLive; oLLink = lLink;
      end
    endcase
  end

endmodule

// File: rtl/omega_router.sv
module omega_router
  import omega_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  parameter int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    inValid,
  input  logic [N-1:0]    inBcast,
  input  logic [N*AW-1:0] inDest,
  input  logic [N*W-1:0]  inData,
  output logic [N-1:0]    outValid,
  output logic [N*W-1:0]  outData,
  output logic [N-1:0]    outBlocked
);

  localparam int HALF    = N / 2;
  localparam int SRC_LO  = W;
  localparam int DEST_LO = W + AW;
  localparam int BC_BIT  = W + 2 * AW;
  localparam int LW      = BC_BIT + 1;

  // link bundle: {bcast, dest, src, data}
  logic          lnkValid [AW+1][N];
  logic [LW-1:0] lnkBus   [AW+1][N];
  logic [N-1:0]  blkChain [AW+1];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign lnkValid[0][i] = inValid[i];
    assign lnkBus[0][i]   = {inBcast[i], inDest[i*AW +: AW], AW'(i), inData[i*W +: W]};
  end

  assign blkChain[0] = '0;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    swStrobe_t    strobes [HALF];
    logic [N-1:0] blkHere;

    // shuffle: link s feeds upper input, link s+HALF the lower input of switch s
    for (genvar s = 0; s < HALF; s++) begin : g_sw
      omega_sw_ctrl u_ctrl (
        .uValid (lnkValid[k][s]),
        .uBcast (lnkBus[k][s][BC_BIT]),
        .uBit   (lnkBus[k][s][DEST_LO + AW - 1 - k]),
        .lValid (lnkValid[k][s+HALF]),
        .lBcast (lnkBus[k][s+HALF][BC_BIT]),
        .lBit   (lnkBus[k][s+HALF][DEST_LO + AW - 1 - k]),
        .strobe (strobes[s])
      );

      omega_sw_dp #(.LW(LW)) u_dp (
        .uValid  (lnkValid[k][s]),
        .uLink   (lnkBus[k][s]),
        .lValid  (lnkValid[k][s+HALF]),
        .lLink   (lnkBus[k][s+HALF]),
        .strobe  (strobes[s]),
        .oUValid (lnkValid[k+1][2*s]),
        .oULink  (lnkBus[k+1][2*s]),
        .oLValid (lnkValid[k+1][2*s+1]),
        .oLLink  (lnkBus[k+1][2*s+1])
      );
    end

    always_comb begin
      blkHere = '0;
      for (int s = 0; s < HALF; s++) begin
        if (lnkValid[k][s] && strobes[s].dropUpper)
          blkHere[lnkBus[k][s][SRC_LO +: AW]] = 1'b1;
        if (lnkValid[k][s+HALF] && strobes[s].dropLower)
          blkHere[lnkBus[k][s+HALF][SRC_LO +: AW]] = 1'b1;
      end
    end

    assign blkChain[k+1] = blkChain[k] | blkHere;
  end

  logic [N-1:0]   nextValid;
  logic [N*W-1:0] nextData;

  always_comb begin
    for (int j = 0; j < N; j++) begin
      nextValid[j]       = lnkValid[AW][j];
      nextData[j*W +: W] = lnkValid[AW][j] ? lnkBus[AW][j][W-1:0] : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= '0;
      outData    <= '0;
      outBlocked <= '0;
    end else begin
      outValid   <= nextValid;
      outData    <= nextData;
      outBlocked <= blkChain[AW];
    end
  end

  // ---------------- assertions ----------------
  for (genvar j = 0; j < N; j++) begin : g_chk
    // R2: a surviving unicast copy leaves the last stage on its own destination link
    assert_dest_match_R2: assert property (@(posedge clk) disable iff (!rstN)
      (lnkValid[AW][j] && !lnkBus[AW][j][BC_BIT]) |-> (lnkBus[AW][j][DEST_LO +: AW] == AW'(j)));
  end

  assert_bcast_fanout_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(inValid) == 1 && (inValid & inBcast) != '0) |=> (outValid == {N{1'b1}}));

  assert_single_unblocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(inValid) == 1) |=> (outBlocked == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid == '0) |=> (outValid == '0 && outBlocked == '0 && outData == '0));

  assert_unicast_conserve_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((inValid & inBcast) == '0) |=>
      (($countones(outValid) + $countones(outBlocked)) == $countones($past(inValid))));

endmodule

// File: tb/omega_router_bench.sv
`timescale 1ns/1ps
module omega_router_bench;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = $clog2(N);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    inValid = '0;
  logic [N-1:0]    inBcast = '0;
  logic [N*AW-1:0] inDest = '0;
  logic [N*W-1:0]  inData = '0;
  logic [N-1:0]    outValid;
  logic [N*W-1:0]  outData;
  logic [N-1:0]    outBlocked;

  logic [N-1:0]    expValid;
  logic [N-1:0]    expBlk;
  logic [N*W-1:0]  expData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  omega_router #(.N(N), .W(W)) u_omega_router (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBcast(inBcast),
    .inDest(inDest), .inData(inData), .outValid(outValid),
    .outData(outData), .outBlocked(outBlocked)
  );

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input string what,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference: shuffle by left rotation, pair adjacent links, route on dest bits MSB first
  task automatic model();
    logic          v  [N]; logic          b  [N];
    logic [AW-1:0] d  [N]; logic [W-1:0]  p  [N]; int src [N];
    logic          sv [N]; logic          sb [N];
    logic [AW-1:0] sd [N]; logic [W-1:0]  sp [N]; int ss  [N];
    expBlk = '0;
    for (int i = 0; i < N; i++) begin
      v[i] = inValid[i]; b[i] = inBcast[i];
      d[i] = inDest[i*AW +: AW]; p[i] = inData[i*W +: W]; src[i] = i;
    end
    for (int k = 0; k < AW; k++) begin
      for (int i = 0; i < N; i++) begin
        int j;
        j = ((i << 1) | (i >> (AW - 1))) & (N - 1);
        sv[j] = v[i]; sb[j] = b[i]; sd[j] = d[i]; sp[j] = p[i]; ss[j] = src[i];
      end
      for (int i = 0; i < N; i++) v[i] = 1'b0;
      for (int q = 0; q < N/2; q++) begin
        int u, l; logic ub, lb, keepU, keepL;
        u = 2*q; l = 2*q + 1;
        ub = sd[u][AW-1-k]; lb = sd[l][AW-1-k];
        keepU = sv[u]; keepL = sv[l];
        if (sv[u] && sv[l]) begin
          if (sb[u]) keepL = 1'b0;
          else if (sb[l]) keepU = 1'b0;
          else if (ub == lb) keepL = 1'b0;
        end
        if (sv[u] && !keepU) expBlk[ss[u]] = 1'b1;
        if (sv[l] && !keepL) expBlk[ss[l]] = 1'b1;
        if (keepU) begin
          for (int o = 0; o < 2; o++)
            if (sb[u] || o == int'(ub)) begin
              v[u+o] = 1'b1; b[u+o] = sb[u]; d[u+o] = sd[u]; p[u+o] = sp[u]; src[u+o] = ss[u];
            end
        end
        if (keepL) begin
          for (int o = 0; o < 2; o++)
            if (sb[l] || o == int'(lb)) begin
              v[u+o] = 1'b1; b[u+o] = sb[l]; d[u+o] = sd[l]; p[u+o] = sp[l]; src[u+o] = ss[l];
            end
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      expValid[i] = v[i];
      expData[i*W +: W] = v[i] ? p[i] : '0;
    end
  endtask

  // called on a falling edge; result checked one rising edge later
  task automatic apply(input string tag);
    model();
    @(negedge clk);
    check(tag, "outValid", N*W'(outValid), N*W'(expValid));
    check(tag, "outBlocked", N*W'(outBlocked), N*W'(expBlk));
    check(tag, "outData", outData, expData);
  endtask

  task automatic randData();
    for (int i = 0; i < N; i++) inData[i*W +: W] = W'($urandom);
  endtask

  initial begin
    int pool [N];
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid in reset", N*W'(outValid), '0);
    check("R1", "outBlocked in reset", N*W'(outBlocked), '0);
    check("R1", "outData in reset", outData, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outValid after reset", N*W'(outValid), '0);

    // R2, R9: every lone unicast
    for (int s = 0; s < N; s++)
      for (int dd = 0; dd < N; dd++) begin
        inValid = '0; inBcast = '0; inDest = '0; randData();
        inValid[s] = 1'b1; inDest[s*AW +: AW] = AW'(dd);
        apply("R2");
      end

    // R6: every lone broadcast
    for (int s = 0; s < N; s++) begin
      inValid = '0; inBcast = '0; randData();
      inValid[s] = 1'b1; inBcast[s] = 1'b1;
      apply("R6");
    end

    // R5, R8: inputs 0 and 4 meet at the first switch, both going to 0; 4 loses
    inValid = '0; inBcast = '0; inDest = '0; randData();
    inValid[0] = 1'b1; inValid[4] = 1'b1;
    apply("R5");
    check("R8", "input 4 blocked", N*W'(outBlocked), N*W'(8'h10));

    // R7: broadcast from 4 beats unicast from 0
    inBcast[4] = 1'b1; randData();
    apply("R7");
    check("R7", "input 0 blocked", N*W'(outBlocked), N*W'(8'h01));

    // R7: two broadcasts, upper (input 0) wins
    inBcast[0] = 1'b1; randData();
    apply("R7");

    // R10: junk on idle ports
    inValid = '0; inBcast = '1; inDest = '1; randData();
    apply("R10");
    check("R10", "outData idle", outData, '0);
    inValid = 8'h01; inBcast = 8'hFE; inDest = '1; inDest[AW-1:0] = AW'(3); randData();
    apply("R10");

    // R3, R4, R5, R8: every full permutation
    for (int idx = 0; idx < 40320; idx++) begin
      int r, left;
      r = idx; left = N;
      for (int i = 0; i < N; i++) pool[i] = i;
      for (int i = 0; i < N; i++) begin
        int f, sel;
        f = 1;
        for (int m = 2; m < N - i; m++) f = f * m;
        sel = r / f; r = r % f;
        inDest[i*AW +: AW] = AW'(pool[sel]);
        for (int m = sel; m < left - 1; m++) pool[m] = pool[m+1];
        left--;
      end
      inValid = '1; inBcast = '0; randData();
      apply("R4");
    end

    // R7, R8, R9, R10: random mixes with sparse broadcasts
    for (int t = 0; t < 20000; t++) begin
      inValid = N'($urandom);
      inDest  = (N*AW)'($urandom);
      inBcast = N'($urandom) & N'($urandom) & N'($urandom);
      randData();
      apply("R8");
    end

    inValid = '0;
    apply("R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule